// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical page frame by reading two levels of translation tables held in memory. It is given a 20-bit virtual page number together with an address-space identifier (ASID) and the kind of access, read or write. It fetches one word from the directory that belongs to that ASID. It then fetches one word from the page table that this directory word points to. It returns the frame number, the page's permission bits and a fault code. The walker has one memory read port, which uses a request/response handshake with no limit on response latency. It handles one walk at a time.

Software sets up the walker through a small write-only register port. It first writes an ASID to a select register and then writes that ASID's directory base word to a data register. A separate enable register switches translation on and off. When translation is off, every request is returned unchanged, without touching memory. A directory base of zero means no tables are installed for that ASID.

Top module: `walk_unit`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid` is 0, `memReq` is 0, translation is off, and every directory base is zero. When translation is on, a walk for an ASID whose base is zero reports fault code 1 with frame 0 and permissions 0, and it issues no memory read.
- R2: Writing bit 0 of the word at config offset 0x10 sets translation on (1) or off (0). When translation is off, the response comes in the cycle after acceptance. It has frame equal to the request page, permissions 3'b111, code 0, and no memory read.
- R3: A write to offset 0x04 selects an ASID, taken from the low data bits. A following write to offset 0x08 stores the base word for that ASID. The directory word is then read from the address `{base[19:0],12'h000} + 4*page[19:10]`.
- R4: If the directory word has bit 28 clear, the walk ends with code 2, frame 0 and permissions 0, after exactly one memory read.
- R5: If bit 28 is set, the second read goes to `{dir[19:0],12'h000} + 4*page[9:0]`. A successful walk returns `rspPfn` equal to entry bits 19:0, and `rspPerm` equal to entry bits {31,30,29} (readable, writable, nonsecure), with code 0.
- R6: A read access to an entry whose bit 31 is clear, or a write access to an entry whose bit 30 is clear, ends with code 3, frame 0 and permissions 0. `rspFault` is 1 exactly when the code is not 0.
- R7: Only one walk is in flight at a time. `reqReady` goes low in the cycle after a request is accepted and stays low until the response has been given. `rspValid` is a single-cycle pulse.
- R8: `memReq` stays high, with `memAddr` stable and word-aligned, until the cycle in which `memRspValid` is seen. Any response latency is accepted.
- R9: The directory address, the access kind and the enable decision are fixed when a request is accepted. Config writes made during a walk do not change that walk's result.
- R10: Each ASID keeps its own base register. A base write changes only the ASID that is selected at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Config write strobe |
| cfgAddr | input | CFG_AW | Config byte offset |
| cfgWdata | input | 32 | Config write data |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker idle, accepts the request |
| reqAsid | input | ASID_W | Address space of the request |
| reqPage | input | 20 | Virtual page number (address bits 31:12) |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| memReq | output | 1 | Table read request |
| memAddr | output | 32 | Byte address of the table word |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Table word read |
| rspValid | output | 1 | Walk result valid, one cycle |
| rspPfn | output | 20 | Physical frame number |
| rspPerm | output | 3 | {readable, writable, nonsecure} |
| rspFault | output | 1 | Walk faulted |
| rspCode | output | 2 | 0 ok, 1 no table, 2 vacant directory word, 3 permission |

## Verification
The assertions assume the following about the memory side: `memRspValid` is raised only while `memReq` is high, it gives exactly one single-cycle response per request, and `reqAsid` names an implemented ASID. The bench's memory model keeps to this. It waits until it sees a request, waits a random 0 to 4 cycles (or a fixed longer delay in one directed case), drives data for exactly one cycle, and then waits for the next request. Config writes and request fields are driven on falling edges and held for whole cycles. A directed case puts config writes in the middle of a walk on purpose.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VPN_W   = 20;
  localparam int FRAME_W = 20;
  localparam int IDX_W   = 10;

  localparam logic [7:0] REG_SEL    = 8'h04;
  localparam logic [7:0] REG_BASE   = 8'h08;
  localparam logic [7:0] REG_ENABLE = 8'h10;

  localparam int NEXT_BIT = 28;
  localparam int RD_BIT   = 31;
  localparam int WR_BIT   = 30;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_NOTABLE = 2'd1,
    FLT_VACANT  = 2'd2,
    FLT_PERM    = 2'd3
  } fault_e;

  typedef struct packed {
    logic   capture;
    logic   takePde;
    logic   finish;
    logic   fromVa;
    logic   fromRsp;
    fault_e code;
  } strobe_t;
endpackage

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int NUM_ASID = 4,
  parameter int ASID_W   = 2,
  parameter int CFG_AW   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [31:0]        cfgWdata,
  input  logic [ASID_W-1:0]  reqAsid,
  input  logic [VPN_W-1:0]   reqPage,
  input  logic               reqWrite,
  input  logic [31:0]        memRspData,
  input  strobe_t            stb,
  output logic               enable,
  output logic               baseZero,
  output logic               pdeNext,
  output logic               permOk,
  output logic [31:0]        memAddr,
  output logic [FRAME_W-1:0] rspPfn,
  output logic [2:0]         rspPerm,
  output fault_e             rspCode
);
  logic [ASID_W-1:0]             selQ;
  logic                          enQ;
  logic [NUM_ASID-1:0][31:0]     baseVec;
  logic [31:0]                   baseSel;
  logic                          wrQ;
  logic [IDX_W-1:0]              ptIdxQ;
  logic [31:0]                   addrQ;
  logic [31:0]                   dirAddr;
  logic [31:0]                   ptAddr;
  logic                          unusedBits;

  wire selWr  = cfgWe && (cfgAddr == CFG_AW'(REG_SEL));
  wire baseWr = cfgWe && (cfgAddr == CFG_AW'(REG_BASE));
  wire enWr   = cfgWe && (cfgAddr == CFG_AW'(REG_ENABLE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      enQ  <= 1'b0;
    end else begin
      if (selWr) selQ <= cfgWdata[ASID_W-1:0];
      if (enWr)  enQ  <= cfgWdata[0];
    end
  end

  for (genvar g = 0; g < NUM_ASID; g++) begin : g_slot
    logic [31:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               slotQ <= '0;
      else if (baseWr && selQ == ASID_W'(g))   slotQ <= cfgWdata;
    end
    assign baseVec[g] = slotQ;
  end

  assign baseSel  = baseVec[reqAsid];
  assign baseZero = (baseSel == '0);
  assign enable   = enQ;
  assign pdeNext  = memRspData[NEXT_BIT];
  assign permOk   = wrQ ? memRspData[WR_BIT] : memRspData[RD_BIT];

  assign dirAddr = {baseSel[FRAME_W-1:0], 12'h000}
                 + {20'h0, reqPage[VPN_W-1:IDX_W], 2'b00};
  assign ptAddr  = {memRspData[FRAME_W-1:0], 12'h000}
                 + {20'h0, ptIdxQ, 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ    <= 1'b0;
      ptIdxQ <= '0;
      addrQ  <= '0;
    end else if (stb.capture) begin
      wrQ    <= reqWrite;
      ptIdxQ <= reqPage[IDX_W-1:0];
      addrQ  <= dirAddr;
    end else if (stb.takePde) begin
      addrQ  <= ptAddr;
    end
  end
  assign memAddr = addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspPfn  <= '0;
      rspPerm <= '0;
      rspCode <= FLT_NONE;
    end else if (stb.finish) begin
      rspCode <= stb.code;
      rspPfn  <= stb.fromVa  ? reqPage
               : stb.fromRsp ? memRspData[FRAME_W-1:0] : '0;
      rspPerm <= stb.fromVa  ? 3'b111
               : stb.fromRsp ? memRspData[31:29] : 3'b000;
    end
  end

  assign unusedBits = ^{baseSel[31:FRAME_W], memRspData[27:FRAME_W]};

  assert_base_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !baseWr |=> $stable(baseVec));

  assert_fault_blank_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && stb.code != FLT_NONE) |=> (rspPfn == '0 && rspPerm == 3'b000));
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memRspValid,
  input  logic    enable,
  input  logic    baseZero,
  input  logic    pdeNext,
  input  logic    permOk,
  output logic    reqReady,
  output logic    memReq,
  output logic    rspValid,
  output strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_DONE} state_e;
  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    rspValid  = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          if (!enable) begin
            stb.finish = 1'b1;
            stb.fromVa = 1'b1;
            nextState  = S_DONE;
          end else if (baseZero) begin
            stb.finish = 1'b1;
            stb.code   = FLT_NOTABLE;
            nextState  = S_DONE;
          end else begin
            nextState  = S_DIR;
          end
        end
      end
      S_DIR: begin
        memReq = 1'b1;
        if (memRspValid) begin
          if (!pdeNext) begin
            stb.finish = 1'b1;
            stb.code   = FLT_VACANT;
            nextState  = S_DONE;
          end else begin
            stb.takePde = 1'b1;
            nextState   = S_TBL;
          end
        end
      end
      S_TBL: begin
        memReq = 1'b1;
        if (memRspValid) begin
          stb.finish = 1'b1;
          if (permOk) stb.fromRsp = 1'b1;
          else        stb.code    = FLT_PERM;
          nextState = S_DONE;
        end
      end
      S_DONE: begin
        rspValid  = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_hold_request_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRspValid) |=> memReq);
endmodule

// File: rtl/walk_unit.sv
module walk_unit
  import walk_pkg::*;
#(
  parameter int NUM_ASID = 4,
  parameter int CFG_AW   = 8,
  localparam int ASID_W  = $clog2(NUM_ASID)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [31:0]        cfgWdata,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ASID_W-1:0]  reqAsid,
  input  logic [VPN_W-1:0]   reqPage,
  input  logic               reqWrite,
  output logic               memReq,
  output logic [31:0]        memAddr,
  input  logic               memRspValid,
  input  logic [31:0]        memRspData,
  output logic               rspValid,
  output logic [FRAME_W-1:0] rspPfn,
  output logic [2:0]         rspPerm,
  output logic               rspFault,
  output logic [1:0]         rspCode
);
  strobe_t stb;
  logic    enable, baseZero, pdeNext, permOk;
  fault_e  codeW;

  walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .enable(enable), .baseZero(baseZero), .pdeNext(pdeNext), .permOk(permOk),
    .reqReady(reqReady), .memReq(memReq), .rspValid(rspValid), .stb(stb)
  );

  walk_dpath #(.NUM_ASID(NUM_ASID), .ASID_W(ASID_W), .CFG_AW(CFG_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .reqAsid(reqAsid), .reqPage(reqPage), .reqWrite(reqWrite),
    .memRspData(memRspData), .stb(stb), .enable(enable), .baseZero(baseZero),
    .pdeNext(pdeNext), .permOk(permOk), .memAddr(memAddr),
    .rspPfn(rspPfn), .rspPerm(rspPerm), .rspCode(codeW)
  );

  assign rspCode  = codeW;
  assign rspFault = (codeW != FLT_NONE);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRspValid) |=> $stable(memAddr));

  assert_addr_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));
endmodule

// File: tb/sim_walk_unit.sv
module sim_walk_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [7:0]  cfgAddr;
  logic [31:0] cfgWdata;
  logic        reqValid, reqReady, reqWrite;
  logic [1:0]  reqAsid;
  logic [19:0] reqPage;
  logic        memReq, memRspValid;
  logic [31:0] memAddr, memRspData;
  logic        rspValid, rspFault;
  logic [19:0] rspPfn;
  logic [2:0]  rspPerm;
  logic [1:0]  rspCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  walk_unit u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqReady(reqReady), .reqAsid(reqAsid), .reqPage(reqPage),
    .reqWrite(reqWrite), .memReq(memReq), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rspValid(rspValid),
    .rspPfn(rspPfn), .rspPerm(rspPerm), .rspFault(rspFault), .rspCode(rspCode)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] memImg [logic [31:0]];
  logic [31:0] baseSh [4];
  logic        enSh;
  int          rdCount;
  logic [31:0] rdAddr [2];
  int          forceLat = 0;
  int          respLat;

  function automatic logic [31:0] memRead(input logic [31:0] a);
    return memImg.exists(a) ? memImg[a] : 32'h0;
  endfunction

  // memory model: one single-cycle response per observed request
  initial begin
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (memReq) begin
        respLat = (forceLat > 0) ? forceLat : $urandom_range(0, 4);
        repeat (respLat) @(negedge clk);
        if (rdCount < 2) rdAddr[rdCount] = memAddr;
        rdCount++;
        memRspData  = memRead(memAddr);
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setBase(input logic [1:0] asid, input logic [31:0] b);
    cfgWrite(8'h04, {30'h0, asid});
    cfgWrite(8'h08, b);
    baseSh[asid] = b;
  endtask

  task automatic setEnable(input logic b);
    cfgWrite(8'h10, {31'h0, b});
    enSh = b;
  endtask

  task automatic predict(input logic [1:0] asid, input logic [19:0] page, input logic wr,
                         output logic [1:0] code, output logic [2:0] perm,
                         output logic [19:0] pfn, output int nrd,
                         output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] pde, pte;
    logic ok;
    code = 0; perm = 0; pfn = 0; nrd = 0; a0 = 0; a1 = 0;
    if (!enSh) begin
      perm = 3'b111; pfn = page;
    end else if (baseSh[asid] == 0) begin
      code = 2'd1;
    end else begin
      a0  = {baseSh[asid][19:0], 12'h000} + {20'h0, page[19:10], 2'b00};
      pde = memRead(a0);
      nrd = 1;
      if (!pde[28]) begin
        code = 2'd2;
      end else begin
        a1  = {pde[19:0], 12'h000} + {20'h0, page[9:0], 2'b00};
        pte = memRead(a1);
        nrd = 2;
        ok  = wr ? pte[30] : pte[31];
        if (ok) begin perm = pte[31:29]; pfn = pte[19:0]; end
        else code = 2'd3;
      end
    end
  endtask

  task automatic runWalk(input logic [1:0] asid, input logic [19:0] page, input logic wr,
                         output logic [1:0] code, output logic [2:0] perm,
                         output logic [19:0] pfn, output int lat, output logic busy);
    @(negedge clk);
    rdCount  = 0;
    reqValid = 1'b1; reqAsid = asid; reqPage = page; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    busy = !reqReady;
    lat = 1;
    while (!rspValid) begin
      @(negedge clk);
      lat++;
    end
    code = rspCode; perm = rspPerm; pfn = rspPfn;
    if (rspFault !== (rspCode != 2'd0)) checkEq("R6 fault flag", {63'h0, rspFault}, {63'h0, rspCode != 2'd0});
  endtask

  task automatic walkCheck(input string tag, input logic [1:0] asid,
                           input logic [19:0] page, input logic wr);
    logic [1:0] eCode, code;
    logic [2:0] ePerm, perm;
    logic [19:0] ePfn, pfn;
    int eN, lat;
    logic [31:0] a0, a1;
    logic busy;
    predict(asid, page, wr, eCode, ePerm, ePfn, eN, a0, a1);
    runWalk(asid, page, wr, code, perm, pfn, lat, busy);
    checkEq(tag, {code, perm, pfn, rdCount[3:0]}, {eCode, ePerm, ePfn, eN[3:0]});
    if (eN >= 1) checkEq({tag, " R3 dir addr"}, {32'h0, rdAddr[0]}, {32'h0, a0});
    if (eN >= 2) checkEq({tag, " R5 table addr"}, {32'h0, rdAddr[1]}, {32'h0, a1});
    checkEq({tag, " R7 busy"}, {63'h0, busy}, 64'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] code;
    logic [2:0] perm;
    logic [19:0] pfn;
    int lat;
    logic busy;
    int seedDummy;
    seedDummy = $urandom(32'd4711);
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgWdata = '0;
    reqValid = 1'b0; reqAsid = '0; reqPage = '0; reqWrite = 1'b0;
    for (int i = 0; i < 4; i++) baseSh[i] = 32'h0;
    enSh = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkEq("R1 reset outputs", {61'h0, reqReady, rspValid, memReq}, {61'h0, 3'b100});

    // R2 bypass while translation off
    runWalk(2'd1, 20'hABCDE, 1'b1, code, perm, pfn, lat, busy);
    checkEq("R2 bypass result", {code, perm, pfn, rdCount[3:0]}, {2'd0, 3'b111, 20'hABCDE, 4'd0});
    checkEq("R2 bypass latency", lat, 1);
    @(negedge clk);
    checkEq("R7 single pulse", {63'h0, rspValid}, 64'h0);

    setEnable(1'b1);
    walkCheck("R1 empty base", 2'd0, 20'h12345, 1'b0);

    // tables: ASID1 directory at frame 0x100, ASID2 at frame 0x180
    setBase(2'd1, 32'hE000_0100);
    setBase(2'd2, 32'hE000_0180);
    for (int k = 0; k < 4; k++) begin
      memImg[32'h0010_0000 + (k*100+7)*4] = 32'hF000_0200 + k;
      memImg[32'h0018_0000 + (k*100+7)*4] = 32'hF000_0300 + k;
      for (int j = 4; j < 16; j++) begin
        memImg[32'h0020_0000 + k*4096 + j*4] = {$urandom_range(0,7), 9'h0, 20'($urandom)};
        memImg[32'h0030_0000 + k*4096 + j*4] = {$urandom_range(0,7), 9'h0, 20'($urandom)};
      end
    end
    memImg[32'h0010_0000 + 5*4]  = 32'hE000_0400;     // vacant: next flag clear
    memImg[32'h0020_0000 + 1*4]  = 32'h8001_2345;     // read only
    memImg[32'h0020_0000 + 2*4]  = 32'h4000_ABCD;     // write only
    memImg[32'h0020_0000 + 3*4]  = 32'hE00F_FFFF;     // all permissions
    memImg[32'h0030_0000 + 3*4]  = 32'hA005_5555;     // other ASID, same slot

    walkCheck("R5 read ok", 2'd1, {10'd7, 10'd3}, 1'b0);
    walkCheck("R5 write ok", 2'd1, {10'd7, 10'd3}, 1'b1);
    walkCheck("R5 read-only read", 2'd1, {10'd7, 10'd1}, 1'b0);
    walkCheck("R6 write to read-only", 2'd1, {10'd7, 10'd1}, 1'b1);
    walkCheck("R6 read of write-only", 2'd1, {10'd7, 10'd2}, 1'b0);
    walkCheck("R4 vacant flag clear", 2'd1, {10'd5, 10'd3}, 1'b0);
    walkCheck("R4 vacant zero word", 2'd1, {10'd900, 10'd0}, 1'b1);
    walkCheck("R10 second asid", 2'd2, {10'd7, 10'd3}, 1'b0);
    walkCheck("R10 untouched asid", 2'd3, {10'd7, 10'd3}, 1'b0);

    // R9 config writes in the middle of a walk
    begin
      logic [1:0] eCode; logic [2:0] ePerm; logic [19:0] ePfn;
      int eN; logic [31:0] a0, a1;
      predict(2'd1, {10'd7, 10'd3}, 1'b0, eCode, ePerm, ePfn, eN, a0, a1);
      forceLat = 8;
      fork
        runWalk(2'd1, {10'd7, 10'd3}, 1'b0, code, perm, pfn, lat, busy);
        begin
          cfgWrite(8'h04, 32'd1);
          cfgWrite(8'h08, 32'h0);
          cfgWrite(8'h10, 32'h0);
        end
      join
      forceLat = 0;
      checkEq("R9 in-flight walk", {code, perm, pfn, rdCount[3:0]}, {eCode, ePerm, ePfn, eN[3:0]});
      checkEq("R8 long latency addr", {32'h0, rdAddr[1]}, {32'h0, a1});
      enSh = 1'b0; baseSh[1] = 32'h0;
      walkCheck("R2 off after write", 2'd1, 20'h00123, 1'b0);
      setEnable(1'b1);
      walkCheck("R1 cleared base", 2'd1, {10'd7, 10'd3}, 1'b0);
      setBase(2'd1, 32'hE000_0100);
    end

    // random walks
    for (int n = 0; n < 150; n++) begin
      logic [1:0] a;
      logic [9:0] d;
      a = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3)) : 2'($urandom_range(1, 2));
      d = ($urandom_range(0, 7) == 0) ? 10'($urandom) : 10'($urandom_range(0, 3) * 100 + 7);
      walkCheck("R5 random", a, {d, 10'($urandom_range(0, 31))}, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule